// File: doc/BRIEF.md
# Windowed Sensor Readout Timing Generator

This block sequences the readout of a rectangular window of an area image sensor. It walks a row counter and a column counter through one frame and produces frame-valid, line-valid and pixel-valid strobes. It also drives the absolute row and column address of the pixel being read. A frame consists of the active rows followed by vertical blanking rows. Each row consists of the active columns followed by horizontal blanking clocks. The total row count can grow when a long exposure width is programmed.

Software programs the window origin, the window size, both blanking intervals, the exposure width and the exposure mode through a simple register write port. Those writes land in a staging set. The staging set is copied into the active set only at a frame boundary, so a frame never changes shape part way through. A freeze bit holds back that copy. An enable bit stops readout and later restarts it at the top of a new frame. A read port returns the staging values and a constant identification word.

Top module: `sensor_readout_timer`

## Requirements
- R1: After reset the registers read back their defaults: first row 10 (address 1), first column 22 (address 2), height-minus-one 479 (address 3), width-minus-one 639 (address 4), horizontal blanking 131 (address 5), vertical-blanking-minus-one 28 (address 6), exposure width 0 (address 7), control 1 (address 8). Readout is running, and the first pixel after reset has row address 10 and column address 22.
- R2: Address 0 always reads 0x8232, and a write to address 0 has no effect on it.
- R3: In each active row, line_valid and pixel_valid are high for exactly width+1 consecutive clocks. Each row lasts width+1 plus the effective horizontal blanking clocks.
- R4: A horizontal blanking value below 9 behaves exactly like 9.
- R5: frame_valid is high for height+1 rows and is low for the rest of the frame. Without exposure stretching, the rest of the frame is vertical-blanking+1 rows.
- R6: During valid pixels, row_addr equals the first-row value plus the row index, and col_addr equals the first-column value plus the column index.
- R7: Writes to addresses 1 to 7 and to control bit 2 go only to staging. They reach the active set at the next frame boundary, so the frame in progress keeps its shape.
- R8: While control bit 1 (freeze) is 1, the active set does not change. After the bit clears, the staged values apply from the next frame boundary.
- R9: While control bit 0 (enable) is 0, all three strobes are low. When the bit is set again, the first clock outputs row 0, column 0 of a new frame.
- R10: With control bit 2 at 0, an exposure width E greater than base rows minus one (base = height+1 + vblank+1) makes the frame E+1 rows long. Otherwise the frame is base rows long.
- R11: With control bit 2 at 1, an exposure width E greater than base rows makes the frame E rows long. E equal to base leaves the frame at base rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (staging values, ID at 0) |
| frame_valid | output | 1 | High during the active rows of a frame |
| line_valid | output | 1 | High during the active columns of an active row |
| pixel_valid | output | 1 | High for each valid pixel |
| row_addr | output | 10 | Absolute row address of the current pixel |
| col_addr | output | 11 | Absolute column address of the current pixel |

## Verification
On every cycle, the assertions check the following. The active set stays put except at a boundary and while frozen. The counters stay inside the row and line limits. The counters are parked at zero while disabled and restart from zero. A frame rises only at row 0, column 0. The whole-frame quantities come only from the bench's sweep over small windows, blanking values and exposure settings: the line run length, the blanking gap, the frame period and the stretched row counts. The same holds for the deferred timing of staged writes and of a released freeze.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int ROW_W      = 9;
    localparam int COL_W      = 10;
    localparam int EXP_W      = 11;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int RCNT_W     = EXP_W + 1;
    localparam int CCNT_W     = COL_W + 1;
    localparam int RADDR_W    = ROW_W + 1;
    localparam int CADDR_W    = COL_W + 1;
    localparam int MIN_HBLANK = 9;
    localparam logic [DATA_W-1:0] ID_VALUE = 16'h8232;

    typedef enum logic [ADDR_W-1:0] {
        REG_ID     = 4'd0,
        REG_ROW0   = 4'd1,
        REG_COL0   = 4'd2,
        REG_HEIGHT = 4'd3,
        REG_WIDTH  = 4'd4,
        REG_HBLANK = 4'd5,
        REG_VBLANK = 4'd6,
        REG_EXPOSE = 4'd7,
        REG_CTRL   = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [ROW_W-1:0] row0;
        logic [COL_W-1:0] col0;
        logic [ROW_W-1:0] height;
        logic [COL_W-1:0] width;
        logic [COL_W-1:0] hblank;
        logic [ROW_W-1:0] vblank;
        logic [EXP_W-1:0] expose;
        logic             full_expose;
    } cfg_t;

    typedef struct packed {
        logic enable;
        logic freeze;
    } ctrl_t;

    localparam cfg_t CFG_DEFAULT = '{
        row0:        ROW_W'(10),
        col0:        COL_W'(22),
        height:      ROW_W'(479),
        width:       COL_W'(639),
        hblank:      COL_W'(131),
        vblank:      ROW_W'(28),
        expose:      EXP_W'(0),
        full_expose: 1'b0
    };

    localparam ctrl_t CTRL_DEFAULT = '{enable: 1'b1, freeze: 1'b0};
endpackage

// File: rtl/srt_regs.sv
module srt_regs
    import srt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              stage_o,
    output ctrl_t             ctrl_o
);
    typedef struct packed {
        cfg_t  stage;
        ctrl_t ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_ROW0:   r_d.stage.row0   = wr_data[ROW_W-1:0];
                REG_COL0:   r_d.stage.col0   = wr_data[COL_W-1:0];
                REG_HEIGHT: r_d.stage.height = wr_data[ROW_W-1:0];
                REG_WIDTH:  r_d.stage.width  = wr_data[COL_W-1:0];
                REG_HBLANK: r_d.stage.hblank = wr_data[COL_W-1:0];
                REG_VBLANK: r_d.stage.vblank = wr_data[ROW_W-1:0];
                REG_EXPOSE: r_d.stage.expose = wr_data[EXP_W-1:0];
                REG_CTRL: begin
                    r_d.ctrl.enable        = wr_data[0];
                    r_d.ctrl.freeze        = wr_data[1];
                    r_d.stage.full_expose  = wr_data[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{stage: CFG_DEFAULT, ctrl: CTRL_DEFAULT};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_ID:     rd_data = ID_VALUE;
            REG_ROW0:   rd_data = DATA_W'(r_q.stage.row0);
            REG_COL0:   rd_data = DATA_W'(r_q.stage.col0);
            REG_HEIGHT: rd_data = DATA_W'(r_q.stage.height);
            REG_WIDTH:  rd_data = DATA_W'(r_q.stage.width);
            REG_HBLANK: rd_data = DATA_W'(r_q.stage.hblank);
            REG_VBLANK: rd_data = DATA_W'(r_q.stage.vblank);
            REG_EXPOSE: rd_data = DATA_W'(r_q.stage.expose);
            REG_CTRL:   rd_data = DATA_W'({r_q.stage.full_expose, r_q.ctrl.freeze, r_q.ctrl.enable});
            default:    rd_data = '0;
        endcase
    end

    assign stage_o = r_q.stage;
    assign ctrl_o  = r_q.ctrl;

    // R7: a width write lands in staging on the following cycle
    a_r7_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_WIDTH) |=> (r_q.stage.width == $past(wr_data[COL_W-1:0])));

    // R2: the identification word never changes
    a_r2_id_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_ID) |-> (rd_data == ID_VALUE));
endmodule

// File: rtl/srt_shadow.sv
module srt_shadow
    import srt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t stage_i,
    input  logic load_i,
    input  logic freeze_i,
    output cfg_t act_o
);
    cfg_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (load_i && !freeze_i) begin
            act_d = stage_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= CFG_DEFAULT;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_o = act_q;

    // R8: frozen settings stay put
    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(act_q));

    // R7: no change to the active set away from a frame boundary
    a_r7_no_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q));
endmodule

// File: rtl/srt_counter.sv
module srt_counter
    import srt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  cfg_t               act_i,
    output logic               boundary_o,
    output logic               fv_o,
    output logic               lv_o,
    output logic [RADDR_W-1:0] row_addr_o,
    output logic [CADDR_W-1:0] col_addr_o
);
    typedef struct packed {
        logic [RCNT_W-1:0] row;
        logic [CCNT_W-1:0] col;
    } cnt_t;

    cnt_t c_d, c_q;

    logic [COL_W-1:0]  hb_eff;
    logic [CCNT_W-1:0] line_last;
    logic [RCNT_W-1:0] base_rows;
    logic [RCNT_W-1:0] exp_rows;
    logic [RCNT_W-1:0] total_rows;
    logic [RCNT_W-1:0] last_row;
    logic              row_end;
    logic              frame_end;

    always_comb begin
        hb_eff    = (act_i.hblank < COL_W'(MIN_HBLANK)) ? COL_W'(MIN_HBLANK) : act_i.hblank;
        line_last = CCNT_W'(act_i.width) + CCNT_W'(hb_eff);
        base_rows = RCNT_W'(act_i.height) + RCNT_W'(act_i.vblank) + RCNT_W'(2);
        exp_rows  = RCNT_W'(act_i.expose);
        if (act_i.full_expose) begin
            total_rows = (exp_rows > base_rows) ? exp_rows : base_rows;
        end else begin
            total_rows = (exp_rows > base_rows - RCNT_W'(1)) ? exp_rows + RCNT_W'(1) : base_rows;
        end
        last_row  = total_rows - RCNT_W'(1);
        row_end   = (c_q.col == line_last);
        frame_end = en_i && row_end && (c_q.row == last_row);

        c_d = c_q;
        if (!en_i) begin
            c_d = '0;
        end else if (row_end) begin
            c_d.col = '0;
            c_d.row = (c_q.row == last_row) ? '0 : c_q.row + RCNT_W'(1);
        end else begin
            c_d.col = c_q.col + CCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign boundary_o = !en_i || frame_end;
    assign fv_o       = en_i && (c_q.row <= RCNT_W'(act_i.height));
    assign lv_o       = fv_o && (c_q.col <= CCNT_W'(act_i.width));
    assign row_addr_o = RADDR_W'(act_i.row0) + RADDR_W'(c_q.row);
    assign col_addr_o = CADDR_W'(act_i.col0) + c_q.col;

    // R3: the column counter never passes the end of the line
    a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.col <= line_last);

    // R10: the row counter stays inside the (possibly stretched) frame
    a_r10_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.row <= last_row);

    // R9: counters park at zero while readout is stopped
    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (c_q.row == '0 && c_q.col == '0));

    // R9: restart begins at the top of a frame
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !$past(en_i)) |-> (c_q.row == '0 && c_q.col == '0));

    // R5: a frame opens only at row 0, column 0
    a_r5_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fv_o) |-> (c_q.row == '0 && c_q.col == '0));
endmodule

// File: rtl/sensor_readout_timer.sv
module sensor_readout_timer
    import srt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               frame_valid,
    output logic               line_valid,
    output logic               pixel_valid,
    output logic [RADDR_W-1:0] row_addr,
    output logic [CADDR_W-1:0] col_addr
);
    cfg_t  stage;
    cfg_t  active;
    ctrl_t ctrl;
    logic  boundary;
    logic  lv;

    srt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .stage_o (stage),
        .ctrl_o  (ctrl)
    );

    srt_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_i  (stage),
        .load_i   (boundary),
        .freeze_i (ctrl.freeze),
        .act_o    (active)
    );

    srt_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl.enable),
        .act_i      (active),
        .boundary_o (boundary),
        .fv_o       (frame_valid),
        .lv_o       (lv),
        .row_addr_o (row_addr),
        .col_addr_o (col_addr)
    );

    assign line_valid  = lv;
    assign pixel_valid = lv;
endmodule

// File: tb/sim_sensor_readout_timer.sv
`timescale 1ns/1ps
module sim_sensor_readout_timer;
    import srt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        frame_valid, line_valid, pixel_valid;
    logic [9:0]  row_addr;
    logic [10:0] col_addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sensor_readout_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_valid(frame_valid),
        .line_valid(line_valid), .pixel_valid(pixel_valid),
        .row_addr(row_addr), .col_addr(col_addr)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 4'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic set_cfg(input int sr, input int sc, input int h, input int w,
                           input int hb, input int vb, input int ex, input int ff);
        wr(8, 0);
        wr(1, sr); wr(2, sc); wr(3, h); wr(4, w);
        wr(5, hb); wr(6, vb); wr(7, ex);
        wr(8, 1 | (ff << 2));
    endtask

    task automatic measure_frame(output int period, output int lvcnt, output int fvcnt,
                                 output int run, output int gap, output int r0,
                                 output int c0, output int rmax, output int pvmis);
        logic prev;
        logic rise;
        int   phase;
        prev = frame_valid;
        do begin
            @(negedge clk);
            rise = frame_valid && !prev;
            prev = frame_valid;
        end while (!rise);
        r0 = int'(row_addr); c0 = int'(col_addr);
        period = 0; lvcnt = 0; fvcnt = 0; run = 0; gap = 0; rmax = 0; pvmis = 0; phase = 0;
        forever begin
            if (line_valid) lvcnt++;
            if (frame_valid) fvcnt++;
            if (pixel_valid != line_valid) pvmis++;
            if (line_valid && int'(row_addr) > rmax) rmax = int'(row_addr);
            if (phase == 0) begin
                if (line_valid) run++;
                else begin phase = 1; gap = 1; end
            end else if (phase == 1) begin
                if (!line_valid) gap++;
                else phase = 2;
            end
            period++;
            prev = frame_valid;
            @(negedge clk);
            if (frame_valid && !prev) break;
        end
    endtask

    function automatic int exp_rows(input int h, input int vb, input int ex, input int ff);
        int base;
        base = h + 1 + vb + 1;
        if (ff != 0) return (ex > base) ? ex : base;
        return (ex > base - 1) ? ex + 1 : base;
    endfunction

    task automatic check_frame(input int sr, input int sc, input int h, input int w,
                               input int hb, input int vb, input int ex, input int ff);
        int period, lvcnt, fvcnt, run, gap, r0, c0, rmax, pvmis;
        int hbe, len, rows;
        hbe  = (hb < 9) ? 9 : hb;
        len  = w + 1 + hbe;
        rows = exp_rows(h, vb, ex, ff);
        measure_frame(period, lvcnt, fvcnt, run, gap, r0, c0, rmax, pvmis);
        check("R3 first line run", run, w + 1);
        check("R3 pixel_valid matches line_valid", pvmis, 0);
        check("R3 valid pixels per frame", lvcnt, (h + 1) * (w + 1));
        if (h >= 1) check("R4 horizontal gap", gap, hbe);
        check("R5 frame_valid clocks", fvcnt, (h + 1) * len);
        check("R10 R11 frame period", period, rows * len);
        check("R6 first row address", r0, sr);
        check("R6 first column address", c0, sc);
        check("R6 last row address", rmax, sr + h);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int d;
        int cnt;
        int period, lvcnt, fvcnt, run, gap, r0, c0, rmax, pvmis;
        logic prevlv;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 frame_valid after reset", frame_valid, 1);
        check("R1 line_valid after reset", line_valid, 1);
        check("R1 row address after reset", row_addr, 10);
        check("R1 column address after reset", col_addr, 22);
        @(negedge clk);
        check("R1 column advances", col_addr, 23);
        rd(1, d); check("R1 first row default", d, 10);
        rd(2, d); check("R1 first column default", d, 22);
        rd(3, d); check("R1 height default", d, 479);
        rd(4, d); check("R1 width default", d, 639);
        rd(5, d); check("R1 hblank default", d, 131);
        rd(6, d); check("R1 vblank default", d, 28);
        rd(7, d); check("R1 exposure default", d, 0);
        rd(8, d); check("R1 control default", d, 1);

        // R2: identification word
        rd(0, d); check("R2 id value", d, 32'h8232);
        wr(0, 16'h1234);
        rd(0, d); check("R2 id after write", d, 32'h8232);

        // Sweep of small windows (R3 R4 R5 R6)
        for (int h = 0; h <= 3; h += (h == 1) ? 2 : 1) begin
            for (int w = 0; w <= 4; w += 4) begin
                for (int hbi = 0; hbi < 4; hbi++) begin
                    for (int vb = 0; vb <= 2; vb += 2) begin
                        int hb;
                        hb = (hbi == 0) ? 0 : (hbi == 1) ? 8 : (hbi == 2) ? 9 : 12;
                        set_cfg(5 + h, 100 + w, h, w, hb, vb, 0, 0);
                        check_frame(5 + h, 100 + w, h, w, hb, vb, 0, 0);
                    end
                end
            end
        end

        // R10: exposure stretching, full-frame bit clear (base = 6)
        set_cfg(3, 7, 3, 2, 9, 1, 5, 0);  check_frame(3, 7, 3, 2, 9, 1, 5, 0);
        set_cfg(3, 7, 3, 2, 9, 1, 6, 0);  check_frame(3, 7, 3, 2, 9, 1, 6, 0);
        set_cfg(3, 7, 3, 2, 9, 1, 9, 0);  check_frame(3, 7, 3, 2, 9, 1, 9, 0);
        // R11: exposure stretching, full-frame bit set
        set_cfg(3, 7, 3, 2, 9, 1, 6, 1);  check_frame(3, 7, 3, 2, 9, 1, 6, 1);
        set_cfg(3, 7, 3, 2, 9, 1, 7, 1);  check_frame(3, 7, 3, 2, 9, 1, 7, 1);
        set_cfg(3, 7, 3, 2, 9, 1, 9, 1);  check_frame(3, 7, 3, 2, 9, 1, 9, 1);

        // R7: a mid-frame write is deferred to the next frame
        set_cfg(4, 30, 2, 3, 9, 1, 0, 0);
        measure_frame(period, lvcnt, fvcnt, run, gap, r0, c0, rmax, pvmis);
        wr(4, 6);
        prevlv = line_valid;
        cnt = 0;
        do begin
            @(negedge clk);
            if (line_valid && !prevlv) cnt = 1;
            prevlv = line_valid;
        end while (cnt == 0);
        run = 0;
        while (line_valid) begin run++; @(negedge clk); end
        check("R7 current frame keeps old width", run, 4);
        check_frame(4, 30, 2, 6, 9, 1, 0, 0);

        // R8: freeze holds the active set, release applies at next boundary
        wr(8, 3);
        wr(4, 2);
        rd(4, d); check("R8 staged width visible", d, 2);
        check_frame(4, 30, 2, 6, 9, 1, 0, 0);
        wr(8, 1);
        check_frame(4, 30, 2, 2, 9, 1, 0, 0);

        // R9: stop and restart
        wr(8, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (frame_valid || line_valid || pixel_valid) cnt++;
            @(negedge clk);
        end
        check("R9 strobes low while stopped", cnt, 0);
        wr(8, 1);
        check("R9 restart row", row_addr, 4);
        check("R9 restart column", col_addr, 30);
        check("R9 restart line_valid", line_valid, 1);
        check("R9 restart frame_valid", frame_valid, 1);
        check_frame(4, 30, 2, 2, 9, 1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule